// File: doc/BRIEF.md
# Posted Write Buffer with Read Forwarding

This block sits between the decoded command stream of a double-data-rate burst memory and its storage array. Each write command carries an address, a two-beat data burst and one enable bit per byte lane. The write goes into a one-entry holding register and does not go to the array. The held write is committed to the array only when the next write command arrives. A write can therefore stay pending across any number of reads and idle cycles without the array port ever having to serve a read and a write in the same cycle.

Reads address the array directly. A read whose address matches a pending held write gets its data from the holding register for the lanes that write enabled. It gets array data for the lanes that write masked off, so the read always returns the newest contents. The block also checks read-to-write turnaround. A write that comes after a read with fewer idle command slots than the minimum in between raises a violation flag.

Top module: `posted_write_buf`

## Requirements
- R1: After reset no write is pending. `rvalid_o`, `turn_err_o` and `arr_we_o` are low, and the first write command after reset drives no array write.
- R2: A write command captures `addr_i`, `wdata_i` and `wmask_i` into the holding register. `wmask_i[i]` enables byte lane i, which is bits `8i+7:8i` of the flattened data. Beat 0 occupies the low word.
- R3: A write command that arrives while a write is pending drives `arr_we_o` high in that same cycle, with the held address, data and mask on the array write port. `arr_we_o` is never high outside a write command cycle.
- R4: A pending write stays unchanged and uncommitted across any number of read and idle cycles.
- R5: Every read command produces `rvalid_o` high in the following cycle, and in no other cycle.
- R6: When a read address equals the address of a pending write, each returned lane whose held mask bit is 1 comes from the held data. Each lane whose held mask bit is 0 comes from the array.
- R7: A read that does not match a pending write returns the array's data for that address.
- R8: A write with fewer than MIN_GAP (default 2) idle cycles since the most recent read raises `turn_err_o` for one cycle, in the cycle after the write. A write with MIN_GAP or more idle cycles does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write command |
| rd_i | input | 1 | Read command (never together with wr_i) |
| addr_i | input | ADDR_W | Command address |
| wdata_i | input | DATA_W | Both write beats, beat 0 in low word |
| wmask_i | input | MASK_W | Per-byte write enable, 1 = write lane |
| arr_we_o | output | 1 | Array write strobe (commit of held write) |
| arr_waddr_o | output | ADDR_W | Array write address |
| arr_wdata_o | output | DATA_W | Array write data |
| arr_wmask_o | output | MASK_W | Array per-byte write enable |
| arr_raddr_o | output | ADDR_W | Array read address |
| arr_rdata_i | input | DATA_W | Array read data, one cycle after the address |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | DATA_W | Merged read data |
| turn_err_o | output | 1 | Read-to-write turnaround violation |

## Verification
The hardest state to reach is a read that needs both sources at once. It happens when an address holds older committed data in the array and a newer, partially masked write to the same address is still pending. A correct reply must splice lanes from both. The stimulus gets there by writing an address in full, forcing that write's commit with a write elsewhere, then writing the same address with a sparse mask and reading it back before any further write. Turnaround gaps of zero, one and exactly two idle slots are driven on purpose. A long pseudo-random phase on a small address set then repeats these overlaps many times.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2
  } cmd_e;
endpackage

// File: rtl/pwb_hold.sv
module pwb_hold #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int MASK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [MASK_W-1:0] wmask_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              commit_o
);
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      mask_q  <= '0;
    end else if (wr_i) begin
      valid_q <= 1'b1;
      addr_q  <= addr_i;
      data_q  <= wdata_i;
      mask_q  <= wmask_i;
    end
  end

  // old entry leaves as the new one lands
  assign commit_o = wr_i & valid_q;
  assign valid_o  = valid_q;
  assign addr_o   = addr_q;
  assign data_o   = data_q;
  assign mask_o   = mask_q;

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> valid_q && addr_q == $past(addr_i) && data_q == $past(wdata_i)
             && mask_q == $past(wmask_i));

  assert_hold_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !wr_i) |=> valid_q && $stable(addr_q) && $stable(data_q) && $stable(mask_q));
endmodule

// File: rtl/pwb_fwd.sv
module pwb_fwd #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int MASK_W = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hold_valid_i,
  input  logic [ADDR_W-1:0] hold_addr_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic [MASK_W-1:0] hold_mask_i,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              rvalid_q;
  logic              hit_q;
  logic [DATA_W-1:0] snap_data_q;
  logic [MASK_W-1:0] snap_mask_q;
  logic              hit_d;

  assign hit_d = rd_i & hold_valid_i & (hold_addr_i == addr_i);

  // snapshot the held entry at read time; array answers one cycle later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q    <= 1'b0;
      hit_q       <= 1'b0;
      snap_data_q <= '0;
      snap_mask_q <= '0;
    end else begin
      rvalid_q <= rd_i;
      hit_q    <= hit_d;
      if (hit_d) begin
        snap_data_q <= hold_data_i;
        snap_mask_q <= hold_mask_i;
      end
    end
  end

  for (genvar l = 0; l < MASK_W; l++) begin : g_lane
    assign rdata_o[l*LANE_W +: LANE_W] = (hit_q && snap_mask_q[l])
                                       ? snap_data_q[l*LANE_W +: LANE_W]
                                       : arr_rdata_i[l*LANE_W +: LANE_W];
  end

  assign rvalid_o = rvalid_q;

  assert_rvalid_after_rd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);

  assert_no_spurious_rvalid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);

  assert_miss_from_array_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !hold_valid_i) |=> rdata_o == arr_rdata_i);
endmodule

// File: rtl/pwb_turn.sv
module pwb_turn
  import pwb_pkg::*;
#(
  parameter int MIN_GAP = 2,
  localparam int CW = $clog2(MIN_GAP + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic wr_i,
  output logic err_o
);
  cmd_e          cmd;
  logic          seen_q;
  logic [CW-1:0] gap_q;
  logic          err_q;
  logic          short_gap;

  always_comb begin
    if (rd_i)      cmd = CMD_RD;
    else if (wr_i) cmd = CMD_WR;
    else           cmd = CMD_IDLE;
  end

  assign short_gap = seen_q && (gap_q < CW'(MIN_GAP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      gap_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (cmd)
        CMD_RD: begin
          seen_q <= 1'b1;
          gap_q  <= '0;
        end
        CMD_WR: begin
          seen_q <= 1'b0;
          err_q  <= short_gap;
        end
        default: if (short_gap) gap_q <= gap_q + 1'b1;
      endcase
    end
  end

  assign err_o = err_q;

  assert_back_to_back_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_i) && wr_i) |=> err_o);

  assert_err_follows_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_i));
endmodule

// File: rtl/posted_write_buf.sv
module posted_write_buf #(
  parameter int ADDR_W  = 8,
  parameter int WORD_W  = 16,
  parameter int LANE_W  = 8,
  parameter int BEATS   = 2,
  parameter int MIN_GAP = 2,
  localparam int DATA_W = BEATS * WORD_W,
  localparam int MASK_W = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [MASK_W-1:0] wmask_i,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_waddr_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  output logic [MASK_W-1:0] arr_wmask_o,
  output logic [ADDR_W-1:0] arr_raddr_o,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              turn_err_o
);
  logic              hold_valid;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic [MASK_W-1:0] hold_mask;
  logic              commit;

  pwb_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .wmask_i  (wmask_i),
    .valid_o  (hold_valid),
    .addr_o   (hold_addr),
    .data_o   (hold_data),
    .mask_o   (hold_mask),
    .commit_o (commit)
  );

  pwb_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_fwd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_i         (rd_i),
    .addr_i       (addr_i),
    .hold_valid_i (hold_valid),
    .hold_addr_i  (hold_addr),
    .hold_data_i  (hold_data),
    .hold_mask_i  (hold_mask),
    .arr_rdata_i  (arr_rdata_i),
    .rvalid_o     (rvalid_o),
    .rdata_o      (rdata_o)
  );

  pwb_turn #(.MIN_GAP(MIN_GAP)) u_turn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .err_o  (turn_err_o)
  );

  assign arr_we_o    = commit;
  assign arr_waddr_o = hold_addr;
  assign arr_wdata_o = hold_data;
  assign arr_wmask_o = hold_mask;
  assign arr_raddr_o = addr_i;

  assert_commit_in_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> wr_i);

  assert_commit_prev_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_i) && wr_i) |-> arr_we_o && arr_waddr_o == $past(addr_i));
endmodule

// File: tb/posted_write_buf_test.sv
`timescale 1ns/1ps
module posted_write_buf_test;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int MASK_W = 4;
  localparam int GAP    = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr = 1'b0, rd = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [MASK_W-1:0] wmask = '0;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_waddr, arr_raddr;
  logic [DATA_W-1:0] arr_wdata, arr_rdata, rdata;
  logic [MASK_W-1:0] arr_wmask;
  logic              rvalid, terr;

  always #2.5 clk = ~clk;

  posted_write_buf uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .wmask_i(wmask), .arr_we_o(arr_we), .arr_waddr_o(arr_waddr),
    .arr_wdata_o(arr_wdata), .arr_wmask_o(arr_wmask), .arr_raddr_o(arr_raddr),
    .arr_rdata_i(arr_rdata), .rvalid_o(rvalid), .rdata_o(rdata), .turn_err_o(terr)
  );

  function automatic logic [DATA_W-1:0] merge(logic [DATA_W-1:0] old_v,
                                              logic [DATA_W-1:0] new_v,
                                              logic [MASK_W-1:0] m);
    logic [DATA_W-1:0] r = old_v;
    for (int i = 0; i < MASK_W; i++)
      if (m[i]) r[i*8 +: 8] = new_v[i*8 +: 8];
    return r;
  endfunction

  // array model: 1-cycle read latency
  logic [DATA_W-1:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = '0;
  initial arr_rdata = '0;
  always @(posedge clk) begin
    if (arr_we) mem[arr_waddr] <= merge(mem[arr_waddr], arr_wdata, arr_wmask);
    arr_rdata <= mem[arr_raddr];
  end

  // reference model
  logic [DATA_W-1:0] gold [256];
  initial for (int i = 0; i < 256; i++) gold[i] = '0;
  bit                m_valid = 0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [DATA_W-1:0] m_data = '0;
  logic [MASK_W-1:0] m_mask = '0;
  bit                m_seen = 0;
  int                m_gap = 0;
  bit                e_rvalid = 0, e_err = 0, e_hit = 0;
  logic [DATA_W-1:0] e_rdata = '0;
  int checks = 0, fails = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit w, bit r, logic [ADDR_W-1:0] a,
                     logic [DATA_W-1:0] d = '0, logic [MASK_W-1:0] m = '1);
    @(negedge clk);
    chk(rvalid == e_rvalid, "R5", "rvalid", 64'(rvalid), 64'(e_rvalid));
    if (e_rvalid)
      chk(rdata == e_rdata, e_hit ? "R6" : "R7", "rdata", 64'(rdata), 64'(e_rdata));
    chk(terr == e_err, "R8", "turn_err", 64'(terr), 64'(e_err));
    wr = w; rd = r; addr = a; wdata = d; wmask = m;
    #1;
    if (w && m_valid) begin
      chk(arr_we == 1'b1, "R3", "commit strobe", 64'(arr_we), 64'd1);
      chk(arr_waddr == m_addr && arr_wmask == m_mask, "R2", "commit addr/mask",
          64'({arr_waddr, arr_wmask}), 64'({m_addr, m_mask}));
      chk(arr_wdata == m_data, "R2", "commit data", 64'(arr_wdata), 64'(m_data));
    end else begin
      chk(arr_we == 1'b0, w ? "R1" : "R4", "no commit", 64'(arr_we), 64'd0);
    end
    e_rvalid = r;
    e_rdata  = gold[a];
    e_hit    = r && m_valid && (m_addr == a);
    e_err    = w && m_seen && (m_gap < GAP);
    if (w) begin
      gold[a] = merge(gold[a], d, m);
      m_valid = 1; m_addr = a; m_data = d; m_mask = m; m_seen = 0;
    end else if (r) begin
      m_seen = 1; m_gap = 0;
    end else if (m_seen) m_gap++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, '0);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(rvalid == 0 && terr == 0 && arr_we == 0, "R1", "reset outputs",
        64'({rvalid, terr, arr_we}), 64'd0);
    rst_n = 1'b1;
    idle(2);
    cyc(1, 0, 8'h10, 32'h1111_2222, 4'hF);      // R1: first write, no commit
    idle(1);
    cyc(0, 1, 8'h10);                            // R6 full forward
    cyc(0, 1, 8'h20);                            // R7 miss
    idle(2);
    cyc(1, 0, 8'h30, 32'hAAAA_BBBB, 4'hF);      // R3 commit 0x10, gap ok
    cyc(0, 1, 8'h10);                            // R7 from array
    idle(2);
    cyc(1, 0, 8'h10, 32'hC3C3_5A5A, 4'b0101);   // partial over committed
    for (int i = 0; i < 5; i++) begin            // R4 many reads
      cyc(0, 1, 8'h10);                          // R6 lane merge
      cyc(0, 1, 8'h30);
    end
    idle(1);
    cyc(1, 0, 8'h40, 32'h0F0F_F0F0, 4'b1010);   // R8 gap 1 -> err
    cyc(0, 1, 8'h40);
    cyc(1, 0, 8'h41, 32'h1234_5678, 4'hF);      // R8 gap 0 -> err
    idle(1);
    cyc(0, 1, 8'h41);
    idle(2);
    cyc(1, 0, 8'h42, 32'h9999_8888, 4'b0011);   // R8 gap exactly 2 -> no err
    cyc(1, 0, 8'h42, 32'h7777_6666, 4'b1100);   // write-write same addr
    cyc(0, 1, 8'h42);
    cyc(0, 1, 8'h40);
    idle(3);
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 9);
      logic [ADDR_W-1:0] a = 8'h50 + 8'($urandom_range(0, 3));
      if (sel < 3)      cyc(1, 0, a, $urandom, 4'($urandom));
      else if (sel < 7) cyc(0, 1, a);
      else              idle(1);
    end
    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule